// File: doc/BRIEF.md
# Status and Control Flag Register

This block is the eight-bit flag register of a small processor core. The register holds four status flags and four control flags. The status flags are negative, overflow, zero and carry, and the ALU updates each one through its own write enable. The control flags are soft reset, halt, pending interrupt request and interrupt enable. Software can see and write every bit, so halting, raising a request or enabling interrupts is simply a flag write.

An explicit flag instruction can do four things to the register: load it from an immediate, AND it with a mask, OR it with a mask, or XOR it with a mask. It can also restore the whole register from a popped stack word. From its state the block derives four outputs: the halt state, an effective interrupt enable, a combinational interrupt-take strobe and a one-cycle soft reset pulse.

Turning on interrupt enable does not open the interrupt gate at once. The gate stays shut until the instruction that follows the enabling write has finished. An enable followed by a return therefore completes without an interrupt landing between the two instructions.

Top module: `stat_ctl_flags`

## Requirements
- R1: A synchronous active-high `rst` clears all eight flags and the lockout state. After reset, `halted`, `int_en_eff`, `int_take` and `soft_rst` are all low.
- R2: The flag bit positions are: 7 negative, 6 overflow, 5 soft reset, 4 halt, 3 interrupt request, 2 interrupt enable, 1 zero, 0 carry. The `fl_op` encodings are: 0 none, 1 load `fl_data`, 2 AND with `fl_data`, 3 OR with `fl_data`, 4 XOR with `fl_data`, 5 pop. Codes 6 and 7 act as none. The result of an operation is visible on `flags_q` after the next clock edge.
- R3: `alu_we`/`alu_val` bit 3 drives negative, bit 2 overflow, bit 1 zero and bit 0 carry. A status flag takes its `alu_val` bit only when its enable is set. ALU updates never change bits 5 to 2.
- R4: In a cycle where `fl_op` is not none, the explicit write sets all eight bits and any simultaneous ALU update is discarded.
- R5: Pop loads `fl_data` into the register but always forces the soft reset bit to 0.
- R6: A write that leaves bit 5 at 1 makes bit 5 and `soft_rst` high for exactly one cycle. Bit 5 then clears by itself.
- R7: `irq_raise` sets the request bit (bit 3). It wins over an explicit write in the same cycle that would clear that bit.
- R8: When interrupt enable goes from 0 to 1, a lockout begins. `int_en_eff` equals enable AND NOT lockout. The lockout ends at the next instruction boundary, meaning an `instr_done` pulse or any cycle spent halted. At the boundary of the enabling instruction itself, `int_take` stays low.
- R9: `int_take` is high when four conditions hold together: the request bit is set, the enable bit is set, the current cycle is a boundary, and either the lockout is clear or `instr_done` ends the locked instruction. After a take, the next edge clears halt and enable and leaves the request bit alone.
- R10: `halted` mirrors bit 4. Once halt is set, it stays set until an interrupt is taken, reset is applied or software writes the bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fl_op | input | 3 | Explicit flag operation code |
| fl_data | input | 8 | Immediate mask, load value or popped word |
| alu_we | input | 4 | Per-flag ALU write enables (N, V, Z, C) |
| alu_val | input | 4 | ALU flag values (N, V, Z, C) |
| irq_raise | input | 1 | Hardware request to set the interrupt request bit |
| instr_done | input | 1 | High in the last cycle of each instruction |
| flags_q | output | 8 | Current flag register contents |
| halted | output | 1 | Processor halt state |
| int_en_eff | output | 1 | Interrupt enable after lockout |
| int_take | output | 1 | Interrupt accepted in this cycle |
| soft_rst | output | 1 | One-cycle soft reset request |

## Verification
The bench first sets interrupt enable together with a pending request. It then checks that no interrupt is taken at the enabling instruction's boundary but one is taken at the end of the following instruction. A design with no lockout, or one that counted the lockout in clock cycles, would take the interrupt too early or too late. A halt combined with enable must wake once the lockout has drained, while a halt without enable must persist through raised requests until reset. A design that treated halt as a boundary too eagerly, or that ignored halt as a boundary, would fail one of these two cases. Further cases cover the soft reset pulse, a pop that carries bit 5, and a hardware raise colliding with an AND-clear. A design with a sticky reset bit, a pop that triggers a reset, or a lost request would report a wrong `flags_q` or `soft_rst`.

// File: rtl/scf_pkg.sv
package scf_pkg;

    localparam int FLAG_W = 8;
    localparam int NSTAT  = 4;

    localparam int BIT_C   = 0;
    localparam int BIT_Z   = 1;
    localparam int BIT_IE  = 2;
    localparam int BIT_IRQ = 3;
    localparam int BIT_HLT = 4;
    localparam int BIT_SRS = 5;
    localparam int BIT_V   = 6;
    localparam int BIT_N   = 7;

    typedef enum logic [2:0] {
        FOP_NONE = 3'd0,
        FOP_LOAD = 3'd1,
        FOP_AND  = 3'd2,
        FOP_OR   = 3'd3,
        FOP_XOR  = 3'd4,
        FOP_POP  = 3'd5
    } fop_e;

    typedef struct packed {
        logic [NSTAT-1:0] we;
        logic [NSTAT-1:0] val;
    } alu_upd_t;

    // ALU status index -> flag bit position (0:C 1:Z 2:V 3:N)
    function automatic int stat_pos(input int idx);
        case (idx)
            0:       return BIT_C;
            1:       return BIT_Z;
            2:       return BIT_V;
            default: return BIT_N;
        endcase
    endfunction

    function automatic logic is_write(input fop_e op);
        return (op == FOP_LOAD) || (op == FOP_AND) || (op == FOP_OR) ||
               (op == FOP_XOR) || (op == FOP_POP);
    endfunction

    function automatic logic [FLAG_W-1:0] apply_op(
        input fop_e              op,
        input logic [FLAG_W-1:0] cur,
        input logic [FLAG_W-1:0] imm
    );
        logic [FLAG_W-1:0] res;
        case (op)
            FOP_LOAD: res = imm;
            FOP_AND:  res = cur & imm;
            FOP_OR:   res = cur | imm;
            FOP_XOR:  res = cur ^ imm;
            FOP_POP: begin
                res = imm;
                res[BIT_SRS] = 1'b0;
            end
            default:  res = cur;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/scf_next.sv
module scf_next
    import scf_pkg::*;
(
    input  logic [FLAG_W-1:0] cur,
    input  fop_e              op,
    input  logic [FLAG_W-1:0] imm,
    input  alu_upd_t          alu,
    input  logic              irq_raise,
    input  logic              take,
    output logic [FLAG_W-1:0] nxt
);

    logic [FLAG_W-1:0] base;
    logic [FLAG_W-1:0] alu_mix;

    // soft reset bit lives for one cycle only
    always_comb begin
        base = cur;
        base[BIT_SRS] = 1'b0;
    end

    always_comb begin
        alu_mix = base;
        for (int i = 0; i < NSTAT; i++) begin
            if (alu.we[i]) begin
                alu_mix[stat_pos(i)] = alu.val[i];
            end
        end
    end

    always_comb begin
        if (is_write(op)) begin
            nxt = apply_op(op, base, imm);
        end else begin
            nxt = alu_mix;
        end
        if (irq_raise) begin
            nxt[BIT_IRQ] = 1'b1;
        end
        if (take) begin
            nxt[BIT_IE]  = 1'b0;
            nxt[BIT_HLT] = 1'b0;
        end
    end

endmodule

// File: rtl/scf_lockout.sv
module scf_lockout (
    input  logic clk,
    input  logic rst,
    input  logic ie_q,
    input  logic ie_d,
    input  logic req_q,
    input  logic halt_q,
    input  logic instr_done,
    output logic en_eff,
    output logic take
);

    logic lock_q;
    logic lock_d;
    logic boundary;

    assign boundary = instr_done | halt_q;
    assign en_eff   = ie_q & ~lock_q;
    assign take     = req_q & ie_q & boundary & (~lock_q | instr_done);

    always_comb begin
        lock_d = lock_q;
        if (!ie_d) begin
            lock_d = 1'b0;
        end else if (!ie_q) begin
            lock_d = 1'b1;
        end else if (boundary) begin
            lock_d = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q <= 1'b0;
        end else begin
            lock_q <= lock_d;
        end
    end

endmodule

// File: rtl/stat_ctl_flags.sv
module stat_ctl_flags
    import scf_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [2:0]  fl_op,
    input  logic [7:0]  fl_data,
    input  logic [3:0]  alu_we,
    input  logic [3:0]  alu_val,
    input  logic        irq_raise,
    input  logic        instr_done,
    output logic [7:0]  flags_q,
    output logic        halted,
    output logic        int_en_eff,
    output logic        int_take,
    output logic        soft_rst
);

    logic [FLAG_W-1:0] flags_r;
    logic [FLAG_W-1:0] flags_d;
    alu_upd_t          alu_upd;
    fop_e              op;

    assign op          = fop_e'(fl_op);
    assign alu_upd.we  = alu_we;
    assign alu_upd.val = alu_val;

    scf_next u_next (
        .cur       (flags_r),
        .op        (op),
        .imm       (fl_data),
        .alu       (alu_upd),
        .irq_raise (irq_raise),
        .take      (int_take),
        .nxt       (flags_d)
    );

    scf_lockout u_lock (
        .clk        (clk),
        .rst        (rst),
        .ie_q       (flags_r[BIT_IE]),
        .ie_d       (flags_d[BIT_IE]),
        .req_q      (flags_r[BIT_IRQ]),
        .halt_q     (flags_r[BIT_HLT]),
        .instr_done (instr_done),
        .en_eff     (int_en_eff),
        .take       (int_take)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_r <= '0;
        end else begin
            flags_r <= flags_d;
        end
    end

    assign flags_q  = flags_r;
    assign halted   = flags_r[BIT_HLT];
    assign soft_rst = flags_r[BIT_SRS];

endmodule

// File: rtl/scf_checker.sv
module scf_checker (
    input logic       clk,
    input logic       rst,
    input logic [2:0] fl_op,
    input logic       irq_raise,
    input logic       instr_done,
    input logic [7:0] flags_q,
    input logic       halted,
    input logic       int_take,
    input logic       soft_rst
);

    a_r6_rst_pulse: assert property (@(posedge clk) disable iff (rst)
        (soft_rst && fl_op == 3'd0) |=> !soft_rst);

    a_r5_pop_no_reset: assert property (@(posedge clk) disable iff (rst)
        (fl_op == 3'd5) |=> !soft_rst);

    a_r7_raise_sets: assert property (@(posedge clk) disable iff (rst)
        irq_raise |=> flags_q[3]);

    a_r9_take_needs_req: assert property (@(posedge clk) disable iff (rst)
        int_take |-> (flags_q[3] && flags_q[2]));

    a_r9_take_clears: assert property (@(posedge clk) disable iff (rst)
        int_take |=> (!flags_q[2] && !flags_q[4]));

    a_r8_lockout: assert property (@(posedge clk) disable iff (rst)
        ($rose(flags_q[2]) && !instr_done) |-> !int_take);

    a_r10_halt_holds: assert property (@(posedge clk) disable iff (rst)
        (halted && !int_take && fl_op == 3'd0) |=> halted);

    a_r3_ctrl_untouched: assert property (@(posedge clk) disable iff (rst)
        (fl_op == 3'd0 && !irq_raise && !int_take) |=> (flags_q[4:2] == $past(flags_q[4:2])));

endmodule

bind stat_ctl_flags scf_checker u_chk (.*);

// File: tb/stat_ctl_flags_tb.sv
module stat_ctl_flags_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] fl_op;
    logic [7:0] fl_data;
    logic [3:0] alu_we;
    logic [3:0] alu_val;
    logic       irq_raise;
    logic       instr_done;
    logic [7:0] flags_q;
    logic       halted;
    logic       int_en_eff;
    logic       int_take;
    logic       soft_rst;

    int total = 0;
    int bad   = 0;
    logic finished = 1'b0;

    always #2 clk = ~clk;

    stat_ctl_flags u_dut (
        .clk(clk), .rst(rst), .fl_op(fl_op), .fl_data(fl_data),
        .alu_we(alu_we), .alu_val(alu_val), .irq_raise(irq_raise),
        .instr_done(instr_done), .flags_q(flags_q), .halted(halted),
        .int_en_eff(int_en_eff), .int_take(int_take), .soft_rst(soft_rst)
    );

    // op, data, alu_we, alu_val, expected flags after the edge
    localparam logic [26:0] VEC [10] = '{
        {3'd1, 8'hC3, 4'h0, 4'h0, 8'hC3},  // R2 load
        {3'd2, 8'h81, 4'h0, 4'h0, 8'h81},  // R2 and
        {3'd3, 8'h42, 4'h0, 4'h0, 8'hC3},  // R2 or
        {3'd4, 8'h0F, 4'h0, 4'h0, 8'hCC},  // R2 xor
        {3'd0, 8'h00, 4'hF, 4'h0, 8'h0C},  // R3 alu clears status only
        {3'd0, 8'h00, 4'h5, 4'hF, 8'h4D},  // R3 per-flag enables V,C
        {3'd1, 8'h00, 4'hF, 4'hF, 8'h00},  // R4 write beats alu
        {3'd5, 8'hA7, 4'h0, 4'h0, 8'h87},  // R5 pop masks reset bit
        {3'd2, 8'h00, 4'h0, 4'h0, 8'h00},  // R2 and-clear
        {3'd0, 8'h00, 4'h2, 4'h2, 8'h02}   // R3 zero only
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [2:0] op, input logic [7:0] d,
                         input logic [3:0] we, input logic [3:0] av,
                         input logic raise, input logic done);
        @(negedge clk);
        fl_op = op; fl_data = d; alu_we = we; alu_val = av;
        irq_raise = raise; instr_done = done;
        #1;
    endtask

    task automatic edge_wait;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst = 1'b1;
        fl_op = 3'd0; fl_data = 8'h00; alu_we = 4'h0; alu_val = 4'h0;
        irq_raise = 1'b0; instr_done = 1'b0;
        edge_wait();
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        fl_op = 3'd0; fl_data = 8'h00; alu_we = 4'h0; alu_val = 4'h0;
        irq_raise = 1'b0; instr_done = 1'b0;
        do_reset();

        // R1 reset state
        chk("R1 flags", flags_q, 8'h00);
        chk("R1 outputs", {4'h0, halted, int_en_eff, int_take, soft_rst}, 8'h00);

        // vector table
        for (int i = 0; i < 10; i++) begin
            drive(VEC[i][26:24], VEC[i][23:16], VEC[i][15:12], VEC[i][11:8], 1'b0, 1'b0);
            edge_wait();
            chk($sformatf("R2-table vec%0d", i), flags_q, VEC[i][7:0]);
            chk($sformatf("R6 no pulse vec%0d", i), {7'h0, soft_rst}, 8'h00);
        end

        // R6 soft reset pulse
        do_reset();
        drive(3'd3, 8'h20, 4'h0, 4'h0, 1'b0, 1'b0);
        edge_wait();
        chk("R6 pulse high", {7'h0, soft_rst}, 8'h01);
        chk("R6 bit5 set", flags_q, 8'h20);
        drive(3'd0, 8'h00, 4'h0, 4'h0, 1'b0, 1'b0);
        edge_wait();
        chk("R6 pulse self-clears", {7'h0, soft_rst}, 8'h00);
        chk("R6 bit5 cleared", flags_q, 8'h00);

        // R7 raise vs explicit clear
        drive(3'd0, 8'h00, 4'h0, 4'h0, 1'b1, 1'b0);
        edge_wait();
        chk("R7 raise sets request", flags_q, 8'h08);
        drive(3'd2, 8'h00, 4'h0, 4'h0, 1'b1, 1'b0);
        edge_wait();
        chk("R7 raise beats and-clear", flags_q, 8'h08);

        // R8 lockout: enable with request pending, enabling instruction ends
        drive(3'd3, 8'h04, 4'h0, 4'h0, 1'b0, 1'b1);
        chk("R8 no take at enabling boundary", {7'h0, int_take}, 8'h00);
        edge_wait();
        chk("R8 enable set", flags_q, 8'h0C);
        drive(3'd0, 8'h00, 4'h0, 4'h0, 1'b0, 1'b0);
        chk("R8 en_eff locked", {7'h0, int_en_eff}, 8'h00);
        chk("R8 no take mid locked instr", {7'h0, int_take}, 8'h00);
        edge_wait();
        drive(3'd0, 8'h00, 4'h0, 4'h0, 1'b0, 1'b1);
        chk("R9 take at end of locked instr", {7'h0, int_take}, 8'h01);
        edge_wait();
        chk("R9 take clears enable", flags_q, 8'h08);
        chk("R9 take drops", {7'h0, int_take}, 8'h00);

        // R10 halt with enable wakes after lockout drains
        drive(3'd1, 8'h1C, 4'h0, 4'h0, 1'b0, 1'b1);
        edge_wait();
        drive(3'd0, 8'h00, 4'h0, 4'h0, 1'b0, 1'b0);
        chk("R10 halted", {7'h0, halted}, 8'h01);
        chk("R8 no take while lock drains", {7'h0, int_take}, 8'h00);
        edge_wait();
        chk("R8 en_eff after drain", {7'h0, int_en_eff}, 8'h01);
        chk("R9 take from halt", {7'h0, int_take}, 8'h01);
        edge_wait();
        chk("R9 wake clears halt and enable", flags_q, 8'h08);
        chk("R10 not halted", {7'h0, halted}, 8'h00);

        // R10 halt without enable persists until reset
        drive(3'd1, 8'h10, 4'h0, 4'h0, 1'b0, 1'b0);
        edge_wait();
        for (int k = 0; k < 3; k++) begin
            drive(3'd0, 8'h00, 4'h0, 4'h0, 1'b1, 1'b0);
            chk("R10 no take without enable", {7'h0, int_take}, 8'h00);
            edge_wait();
        end
        chk("R10 halt persists", flags_q, 8'h18);
        do_reset();
        chk("R1 reset ends halt", {flags_q[7:1], halted}, 8'h00);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule